// File: doc/BRIEF.md
# Dual Event Performance Counter

The block holds two independent 48-bit event counters behind a small word-addressed register window. Each counter has a control word that picks one of 64 event codes and holds a pair of run bits. A counter advances only while both run bits are set. While stopped it keeps its value, and software can zero it. Event sources arrive as a vector of single-cycle pulses, one bit per event code. One code needs no input at all and counts every clock cycle.

Software configures a counter by writing its control word. It reads the count through a high word and a low word. Reads use a strobe, and the data appears on the read port one cycle after the strobe. Counters wrap silently at 2^48.

Register window (word index on `reg_addr`): 0 reserved, 1 control A, 2 control B, 3 count A high, 4 count A low, 5 count B high, 6 count B low, 7 unmapped.

Top module: `dual_perf_counter`

## Requirements
- R1: After reset, both control words and all four count words read 0, and both counters are stopped with event code 0.
- R2: A control write stores the data ANDed with 0x0000C13F. Only bit 15, bit 14, bit 8 and bits 5:0 are kept, and the stored value reads back from the control address.
- R3: A counter advances only while its stored bit 15 (enable) and bit 14 (go) are both 1. With only one of them set, the count does not change.
- R4: While running with event code 0x23 (bits 5:0 of the control word), the count increases by one on every clock. The first increment is at the edge after the starting write, and the edge of a stopping write still counts.
- R5: While running with any other code, the count increases by one on each clock where `evt_pulse[code]` is 1, and only for codes 0x01–0x0B, 0x0D–0x1A, 0x21–0x25 and 0x27–0x29. Any other code never increments, even with every event bit high.
- R6: A control write with bit 13 (clear) zeroes the count only if the counter was stopped before that write. If the counter was running, the clear is ignored, even when the same write stops it.
- R7: A control write without both bit 15 and bit 14 set stops the counter, and the count is kept unchanged.
- R8: A write that changes the code while running switches the counted event from the next clock on. The accumulated count is kept, and the write's own clock still counts the old event.
- R9: The high count word returns count bits 47:32 in bits 15:0 with bits 31:16 zero. The low count word returns bits 31:0.
- R10: Writes to the count addresses, to address 0 and to address 7 change nothing. Reads of address 0 and address 7 return 0.
- R11: Writing or counting on one counter never changes the other counter.
- R12: `reg_rdata` is loaded from the addressed word at the clock edge where `reg_rd` is 1, and holds its value while `reg_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the time base for code 0x23 |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the addressed word |
| reg_rd | input | 1 | Read strobe; data valid on the next cycle |
| reg_addr | input | 3 | Word index into the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_pulse | input | 64 | One pulse bit per event code |

## Verification
The bound checker watches several properties on every clock. A stopped counter never moves unless a clear is taken. A running cycle counter steps by exactly one, and a counter on an undefined code never moves. A clear taken while stopped yields zero. Read data holds between strobes, and both count words return the right slices.

Other behaviours can only be shown by the bench's scenarios. These are the masked control readback, the exact pulse totals for each code, the code switch in the middle of a run, and the stop-and-clear write that must keep its count. The bench also shows that writes to read-only or unmapped words are ignored and that the two counters stay apart.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
   localparam int NUM_CTR = 2;
   localparam int REG_AW  = 3;
   localparam int EN_BIT  = 15;
   localparam int GO_BIT  = 14;
   localparam int CLR_BIT = 13;
   localparam logic [31:0] CTRL_KEEP  = 32'h0000_C13F;
   localparam logic [5:0]  CYCLE_CODE = 6'h23;

   function automatic logic [REG_AW-1:0] ctrl_addr(int idx);
      return REG_AW'(1 + idx);
   endfunction

   function automatic logic [REG_AW-1:0] hi_addr(int idx);
      return REG_AW'(3 + 2 * idx);
   endfunction

   function automatic logic [REG_AW-1:0] lo_addr(int idx);
      return REG_AW'(4 + 2 * idx);
   endfunction

   // codes that name an external event input
   function automatic logic code_is_event(logic [5:0] c);
      return (c >= 6'h01 && c <= 6'h0B) || (c >= 6'h0D && c <= 6'h1A) ||
             (c >= 6'h21 && c <= 6'h25) || (c >= 6'h27 && c <= 6'h29);
   endfunction
endpackage

// File: rtl/dpc_ctrl_reg.sv
module dpc_ctrl_reg
   import dpc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CODE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              running,
   output logic [CODE_W-1:0] code,
   output logic              clr
);
   localparam logic [DATA_W-1:0] KEEP = DATA_W'(CTRL_KEEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctrl_q <= '0;
      else if (wr) ctrl_q <= wdata & KEEP;
   end

   assign running = ctrl_q[EN_BIT] & ctrl_q[GO_BIT];
   assign code    = ctrl_q[CODE_W-1:0];
   // clear is judged against the state before this write
   assign clr     = wr & wdata[CLR_BIT] & ~running;
endmodule

// File: rtl/dpc_event_sel.sv
module dpc_event_sel
   import dpc_pkg::*;
#(
   parameter int CODE_W  = 6,
   parameter int NUM_EVT = 64
) (
   input  logic [CODE_W-1:0]  code,
   input  logic [NUM_EVT-1:0] evt,
   output logic               hit
);
   always_comb begin
      if (6'(code) == CYCLE_CODE) hit = 1'b1;
      else                        hit = code_is_event(6'(code)) & evt[code];
   end
endmodule

// File: rtl/dpc_counter.sv
module dpc_counter #(
   parameter int CNT_W = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/dpc_read_mux.sv
module dpc_read_mux
   import dpc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 48
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              rd,
   input  logic [REG_AW-1:0]                 addr,
   input  logic [NUM_CTR-1:0][DATA_W-1:0]    ctrl_all,
   input  logic [NUM_CTR-1:0][CNT_W-1:0]     cnt_all,
   output logic [DATA_W-1:0]                 rdata
);
   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM_CTR; i++) begin
         if (addr == ctrl_addr(i)) sel = ctrl_all[i];
         if (addr == hi_addr(i))   sel = DATA_W'(cnt_all[i][CNT_W-1:DATA_W]);
         if (addr == lo_addr(i))   sel = cnt_all[i][DATA_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (rd) rdata <= sel;
   end
endmodule

// File: rtl/dual_perf_counter.sv
module dual_perf_counter
   import dpc_pkg::*;
#(
   parameter int CNT_W   = 48,
   parameter int DATA_W  = 32,
   parameter int CODE_W  = 6,
   parameter bit REG_EVT = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_wr,
   input  logic                     reg_rd,
   input  logic [REG_AW-1:0]        reg_addr,
   input  logic [DATA_W-1:0]        reg_wdata,
   output logic [DATA_W-1:0]        reg_rdata,
   input  logic [(1<<CODE_W)-1:0]   evt_pulse
);
   localparam int NUM_EVT = 1 << CODE_W;

   generate
      if (CODE_W != 6) begin : g_bad_code
         $error("CODE_W must be 6");
      end
      if (CNT_W <= DATA_W || CNT_W > 2 * DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie in (DATA_W, 2*DATA_W]");
      end
      if (DATA_W < 16) begin : g_bad_data
         $error("DATA_W must hold the control bits");
      end
   endgenerate

   logic [NUM_EVT-1:0] evt_src;

   generate
      if (REG_EVT) begin : g_evt_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) evt_src <= '0;
            else        evt_src <= evt_pulse;
         end
      end else begin : g_evt_comb
         assign evt_src = evt_pulse;
      end
   endgenerate

   logic [NUM_CTR-1:0][DATA_W-1:0] ctrl_all;
   logic [NUM_CTR-1:0][CNT_W-1:0]  cnt_all;
   logic [NUM_CTR-1:0]             run_vec;
   logic [NUM_CTR-1:0][CODE_W-1:0] code_vec;

   for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
      logic wr_ctl, clr, hit;
      assign wr_ctl = reg_wr && (reg_addr == ctrl_addr(g));

      dpc_ctrl_reg #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_ctl (
         .clk(clk), .rst_n(rst_n), .wr(wr_ctl), .wdata(reg_wdata),
         .ctrl_q(ctrl_all[g]), .running(run_vec[g]), .code(code_vec[g]), .clr(clr)
      );

      dpc_event_sel #(.CODE_W(CODE_W), .NUM_EVT(NUM_EVT)) u_sel (
         .code(code_vec[g]), .evt(evt_src), .hit(hit)
      );

      dpc_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk(clk), .rst_n(rst_n), .clr(clr), .inc(run_vec[g] & hit),
         .cnt_q(cnt_all[g])
      );
   end

   dpc_read_mux #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd(reg_rd), .addr(reg_addr),
      .ctrl_all(ctrl_all), .cnt_all(cnt_all), .rdata(reg_rdata)
   );
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker
   import dpc_pkg::*;
#(
   parameter int CNT_W  = 48,
   parameter int DATA_W = 32,
   parameter int CODE_W = 6
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             reg_wr,
   input logic                             reg_rd,
   input logic [REG_AW-1:0]                reg_addr,
   input logic                             wr_clr,
   input logic [DATA_W-1:0]                reg_rdata,
   input logic [NUM_CTR-1:0]               run_vec,
   input logic [NUM_CTR-1:0][CODE_W-1:0]   code_vec,
   input logic [NUM_CTR-1:0][CNT_W-1:0]    cnt_all
);
   // R12
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));

   for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
      logic clr_wr;
      assign clr_wr = reg_wr && reg_addr == ctrl_addr(i) && wr_clr;

      // R1
      reset_state_chk: assert property (@(posedge clk)
         !rst_n |=> (cnt_all[i] == '0 && !run_vec[i] && code_vec[i] == '0));

      // R3
      stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!run_vec[i] && !clr_wr) |=> cnt_all[i] == $past(cnt_all[i]));

      // R4
      cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (run_vec[i] && 6'(code_vec[i]) == CYCLE_CODE) |=>
            cnt_all[i] == $past(cnt_all[i]) + 1'b1);

      // R5
      undef_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (run_vec[i] && !code_is_event(6'(code_vec[i])) &&
          6'(code_vec[i]) != CYCLE_CODE) |=> cnt_all[i] == $past(cnt_all[i]));

      // R6
      clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_wr && !run_vec[i]) |=> cnt_all[i] == '0);

      // R9
      hi_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_rd && reg_addr == hi_addr(i)) |=>
            reg_rdata == DATA_W'($past(cnt_all[i][CNT_W-1:DATA_W])));

      // R9
      lo_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_rd && reg_addr == lo_addr(i)) |=>
            reg_rdata == $past(cnt_all[i][DATA_W-1:0]));
   end
endmodule

bind dual_perf_counter dpc_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
   .wr_clr(reg_wdata[dpc_pkg::CLR_BIT]), .reg_rdata(reg_rdata),
   .run_vec(run_vec), .code_vec(code_vec), .cnt_all(cnt_all)
);

// File: tb/dual_perf_counter_tb.sv
module dual_perf_counter_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [2:0] A_NONE = 3'd0, A_C0 = 3'd1, A_C1 = 3'd2,
                          A_H0 = 3'd3, A_L0 = 3'd4, A_H1 = 3'd5, A_L1 = 3'd6, A_UN = 3'd7;
   localparam int NV = 14;
   // {code, pulse pattern over 8 cycles, expected count}
   localparam logic [29:0] VEC [NV] = '{
      {6'h01, 8'hB1, 16'd4}, {6'h0B, 8'hFF, 16'd8}, {6'h0C, 8'hFF, 16'd0},
      {6'h0D, 8'h01, 16'd1}, {6'h1A, 8'h80, 16'd1}, {6'h1B, 8'hFF, 16'd0},
      {6'h20, 8'hFF, 16'd0}, {6'h21, 8'h0F, 16'd4}, {6'h23, 8'h00, 16'd9},
      {6'h26, 8'hFF, 16'd0}, {6'h29, 8'hAA, 16'd4}, {6'h2A, 8'hFF, 16'd0},
      {6'h00, 8'hFF, 16'd0}, {6'h3F, 8'hFF, 16'd0}};

   logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic [63:0] evt_pulse = '0;
   int tests = 0, fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_perf_counter u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(A_C0, v); check("R1 ctrl0", v, 0);
      rd(A_C1, v); check("R1 ctrl1", v, 0);
      rd(A_L0, v); check("R1 lo0", v, 0);
      rd(A_H0, v); check("R1 hi0", v, 0);
      rd(A_L1, v); check("R1 lo1", v, 0);
      rd(A_H1, v); check("R1 hi1", v, 0);

      // R2 masking
      wr(A_C0, 32'h1234_5678);
      rd(A_C0, v); check("R2 masked go-only", v, 32'h0000_4038);
      wr(A_C0, 32'hFFFF_FFFF);
      rd(A_C0, v); check("R2 masked all-ones", v, 32'h0000_C13F);
      evt_pulse = '1; idle(5); evt_pulse = '0;
      wr(A_C0, 32'h0);
      rd(A_L0, v); check("R5 code 0x3F stays zero", v, 0);

      // R3 one run bit only
      wr(A_C0, 32'h0000_8023); idle(6);
      rd(A_L0, v); check("R3 enable only", v, 0);
      wr(A_C0, 32'h0000_4023); idle(6);
      rd(A_L0, v); check("R3 go only", v, 0);
      wr(A_C0, 32'h0);

      // R5 R4 vector table
      for (int k = 0; k < NV; k++) begin
         logic [5:0] c; logic [7:0] p; logic [15:0] e;
         {c, p, e} = VEC[k];
         wr(A_C0, 32'h0000_2000);
         wr(A_C0, 32'h0000_C000 | 32'(c));
         for (int j = 0; j < 8; j++) begin
            evt_pulse = p[j] ? '1 : ~(64'd1 << c);
            @(negedge clk);
         end
         evt_pulse = '0;
         wr(A_C0, 32'(c));
         rd(A_L0, v);
         check($sformatf("R5/R4 table code %h", c), v, 32'(e));
      end

      // R6 clear ignored while running, R7 stop keeps, R9 hi word
      wr(A_C1, 32'h0000_C023); idle(5);
      wr(A_C1, 32'h0000_E023); idle(3);
      wr(A_C1, 32'h0000_0023);
      rd(A_L1, v); check("R6 clear ignored while running", v, 10);
      idle(4);
      rd(A_L1, v); check("R7 stopped count kept", v, 10);
      rd(A_H1, v); check("R9 high word", v, 0);
      rd(A_C1, v); check("R2 ctrl1 readback", v, 32'h0000_0023);
      wr(A_C1, 32'h0000_2000);
      rd(A_L1, v); check("R6 clear while stopped", v, 0);
      wr(A_C1, 32'h0000_C023); idle(2);
      wr(A_C1, 32'h0000_2000);
      rd(A_L1, v); check("R6 stop+clear while running keeps", v, 3);

      // R8 code switch while running
      wr(A_C0, 32'h0000_2000);
      wr(A_C0, 32'h0000_C001);
      evt_pulse = 64'h6; idle(3);
      wr(A_C0, 32'h0000_C002);
      evt_pulse = 64'h2; idle(2);
      evt_pulse = 64'h4; idle(3);
      evt_pulse = '0;
      wr(A_C0, 32'h0000_0002);
      rd(A_L0, v); check("R8 switch keeps count", v, 7);
      rd(A_L1, v); check("R11 other counter untouched", v, 3);

      // R10 read-only and unmapped words
      wr(A_H0, '1); wr(A_L0, '1); wr(A_H1, '1); wr(A_L1, '1);
      wr(A_NONE, '1); wr(A_UN, '1);
      rd(A_L0, v); check("R10 lo0 unchanged", v, 7);
      rd(A_L1, v); check("R10 lo1 unchanged", v, 3);
      rd(A_H0, v); check("R10 hi0 unchanged", v, 0);
      rd(A_C0, v); check("R10 ctrl0 unchanged", v, 32'h0000_0002);
      rd(A_C1, v); check("R10 ctrl1 unchanged", v, 32'h0000_0000);
      rd(A_NONE, v); check("R10 offset 0 reads zero", v, 0);
      rd(A_C0, v);
      rd(A_UN, v); check("R10 unmapped reads zero", v, 0);

      // R12 hold without strobe
      rd(A_L0, v);
      reg_addr = A_C0; idle(2);
      check("R12 rdata holds", reg_rdata, 7);

      // R1 reset mid-run
      wr(A_C0, 32'h0000_C023); idle(3);
      rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(3);
      rd(A_L0, v); check("R1 reset clears count", v, 0);
      rd(A_C0, v); check("R1 reset stops counter", v, 0);
      rd(A_L1, v); check("R1 reset clears other", v, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule